// File: doc/BRIEF.md
# Reloading External Event Down-Counter

This block is a single timer channel that counts events arriving on an asynchronous input pin. The pin is brought into the clock domain by a two-flop synchronizer. It can optionally pass through a small digital filter that rejects short glitches. A selectable edge of the resulting level decrements a 16-bit count register. When an edge arrives while the count is zero, the channel reloads the count from a 16-bit data register, carries on counting and raises a one-clock interrupt pulse.

Software drives the channel through a small register interface with four word addresses:

- **Reload data register.** Holds the value copied into the counter.
- **Count register.** Can be read at any time, including while the channel runs.
- **Mode register.** Holds the edge select and the filter enable. It is locked while the channel runs.
- **Control/status register.** Carries self-clearing start and stop triggers and the run flag.

Start copies the reload value into the counter and then waits for edges. Stop freezes the count where it stands.

Top module: `evcnt_channel`

## Requirements
- R1: After reset the run flag is 0. The count, reload data and mode registers all read back as 0, and the interrupt output is low.
- R2: A write to address 3 with bit 0 set (start) sets the run flag and copies the reload data register into the count register. Bits 1:0 of address 3 always read back as 0, and bit 2 reads back the run flag.
- R3: While running, each qualifying edge of the conditioned input decrements the count register by one.
- R4: A qualifying edge that arrives while the count is 0 reloads the count from the data register and raises `irq_o` for exactly one clock. With reload value N, one interrupt therefore occurs every N+1 edges.
- R5: A write to address 3 with bit 1 set (stop) clears the run flag. The count is then held, and input edges have no effect on it or on `irq_o`. When both bits are written together, stop wins.
- R6: A new reload value written while running does not disturb the current count. It takes effect at the next reload.
- R7: Address 1 returns the live count register, including while running. Every register read returns its value one clock after `rd_addr` is presented.
- R8: A write to address 2 (mode) while the run flag is set is ignored. While the run flag is clear, such a write takes effect.
- R9: Mode bits 1:0 select the qualifying edge: 00 falling, 01 rising, 10 both, 11 treated as falling.
- R10: With mode bit 2 clear, a one-clock input pulse is counted. With mode bit 2 set, the conditioned level changes only after two consecutive equal synchronized samples, so a one-clock pulse is rejected and a three-clock pulse is counted.
- R11: A pin change that arrives before clock edge k produces its counter and interrupt update at edge k+3 without the filter, or at edge k+4 with the filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 16 | Registered read data, one clock after `rd_addr` |
| event_pin | input | 1 | Asynchronous event input |
| run_o | output | 1 | Run flag |
| irq_o | output | 1 | One-clock interrupt pulse on reload |

## Verification
Three latencies matter in this block:

- **Register writes.** They act at the clock edge that samples them, so the run flag and a start-time load are visible after that edge.
- **Register reads.** They return one clock after the address is presented, so the bench sets the address after a falling edge and samples after the following falling edge.
- **Pin changes.** These are the slowest: the effect lands three clock edges after the edge that first sees the pin, or four with the filter on.

For counting checks the bench waits eight cycles after every pin change before it reads, which covers both latencies. A dedicated test samples `irq_o` at every falling edge to pin down the exact edge on which the pulse appears and to show that it lasts one clock.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_RSVD = 2'b11
  } edge_sel_e;

  localparam int ADDR_RELOAD = 0;
  localparam int ADDR_COUNT  = 1;
  localparam int ADDR_MODE   = 2;
  localparam int ADDR_CTRL   = 3;

  localparam int CTRL_START  = 0;
  localparam int CTRL_STOP   = 1;
  localparam int STAT_RUN    = 2;
  localparam int MODE_FILT   = 2;
endpackage

// File: rtl/evcnt_infilter.sv
module evcnt_infilter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_DEPTH  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic filt_en_i,
  output logic lvl_o
);
  localparam int HW = (FILT_DEPTH > 1) ? FILT_DEPTH - 1 : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HW-1:0]          hist_q;
  logic                   lvl_q;
  logic                   s_now;
  logic                   settled;

  assign s_now   = sync_q[SYNC_STAGES-1];
  assign settled = (hist_q == {HW{s_now}});

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      hist_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      if (HW > 1) hist_q <= {hist_q[HW-2:0], s_now};
      else        hist_q <= {HW{s_now}};
      if (!filt_en_i || settled) lvl_q <= s_now;
    end
  end

  assign lvl_o = lvl_q;

  // R10: with filtering, the level moves only after matching samples
  a_r10_filter_settled: assert property (@(posedge clk) disable iff (rst)
    ($past(filt_en_i) && (lvl_q != $past(lvl_q))) |->
      ($past(hist_q) == {HW{lvl_q}}));
endmodule

// File: rtl/evcnt_edge.sv
module evcnt_edge
  import evcnt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl_i,
  input  edge_sel_e sel_i,
  output logic      hit_o
);
  logic lvl_d;
  logic rise;
  logic fall;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= lvl_i;
  end

  assign rise = lvl_i & ~lvl_d;
  assign fall = ~lvl_i & lvl_d;

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: hit_o = rise;
      EDGE_BOTH: hit_o = rise | fall;
      default:   hit_o = fall;
    endcase
  end

  // R9: a hit always coincides with a level change
  a_r9_hit_on_change: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (lvl_i != lvl_d));
endmodule

// File: rtl/evcnt_core.sv
module evcnt_core #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] reload_i,
  output logic              run_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic              run_q;
  logic [DATA_W-1:0] cnt_q;
  logic              irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (stop_i) begin
        run_q <= 1'b0;
      end else if (start_i) begin
        run_q <= 1'b1;
        cnt_q <= reload_i;
      end else if (run_q && hit_i) begin
        if (cnt_q == '0) begin
          cnt_q <= reload_i;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  assign run_o = run_q;
  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  // R2: start loads the count and raises the run flag
  a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
    (start_i && !stop_i) |=> (run_q && cnt_q == $past(reload_i)));
  // R3: an edge on a non-zero count takes exactly one off
  a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
    (run_q && hit_i && !start_i && !stop_i && cnt_q != '0) |=>
      (cnt_q == $past(cnt_q) - ONE));
  // R4: the interrupt only follows a running edge at zero
  a_r4_irq_at_zero: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($past(cnt_q) == '0 && $past(run_q) && $past(hit_i)));
  // R5: a stopped channel holds its count
  a_r5_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !start_i) |=> ($stable(cnt_q) && !irq_q));
endmodule

// File: rtl/evcnt_channel.sv
module evcnt_channel
  import evcnt_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              event_pin,
  output logic              run_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] reload_q;
  edge_sel_e         sel_q;
  logic              filt_q;
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] rd_q;
  logic              run;
  logic              lvl;
  logic              hit;
  logic              wr_reload;
  logic              wr_mode;
  logic              wr_ctrl;
  logic              start;
  logic              stop;

  assign wr_reload = wr_en && (wr_addr == ADDR_W'(ADDR_RELOAD));
  assign wr_mode   = wr_en && (wr_addr == ADDR_W'(ADDR_MODE));
  assign wr_ctrl   = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  assign start     = wr_ctrl && wr_data[CTRL_START];
  assign stop      = wr_ctrl && wr_data[CTRL_STOP];

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      sel_q    <= EDGE_FALL;
      filt_q   <= 1'b0;
    end else begin
      if (wr_reload) reload_q <= wr_data;
      if (wr_mode && !run) begin
        sel_q  <= edge_sel_e'(wr_data[1:0]);
        filt_q <= wr_data[MODE_FILT];
      end
    end
  end

  evcnt_infilter #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_DEPTH (FILT_DEPTH)
  ) u_infilter (
    .clk      (clk),
    .rst      (rst),
    .pin_i    (event_pin),
    .filt_en_i(filt_q),
    .lvl_o    (lvl)
  );

  evcnt_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl_i(lvl),
    .sel_i(sel_q),
    .hit_o(hit)
  );

  evcnt_core #(
    .DATA_W(DATA_W)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .stop_i  (stop),
    .hit_i   (hit),
    .reload_i(reload_q),
    .run_o   (run),
    .cnt_o   (cnt),
    .irq_o   (irq_o)
  );

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      ADDR_W'(ADDR_RELOAD): rd_next = reload_q;
      ADDR_W'(ADDR_COUNT):  rd_next = cnt;
      ADDR_W'(ADDR_MODE): begin
        rd_next[1:0]       = sel_q;
        rd_next[MODE_FILT] = filt_q;
      end
      default:              rd_next[STAT_RUN] = run;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_next;
  end

  assign rd_data = rd_q;
  assign run_o   = run;

  // R8: mode writes while running leave the mode untouched
  a_r8_mode_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_mode && run) |=> ($stable(sel_q) && $stable(filt_q)));
  // R6: reload writes do not disturb a running count without an edge
  a_r6_reload_no_disturb: assert property (@(posedge clk) disable iff (rst)
    (wr_reload && run && !hit && !start && !stop) |=> $stable(cnt));
endmodule

// File: tb/test_evcnt_channel.sv
module test_evcnt_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        event_pin = 1'b0;
  logic        run_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  int irq_cnt = 0;
  int irq_len = 0;
  int irq_max = 0;

  always #4 clk = ~clk;

  evcnt_channel i_evcnt_channel (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .event_pin(event_pin), .run_o(run_o), .irq_o(irq_o)
  );

  always @(negedge clk) begin
    if (irq_o) begin
      irq_cnt = irq_cnt + 1;
      irq_len = irq_len + 1;
      if (irq_len > irq_max) irq_max = irq_len;
    end else begin
      irq_len = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_addr = 2'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic pin_to(input logic v);
    @(negedge clk);
    event_pin = v;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse(input int width);
    @(negedge clk);
    event_pin = 1'b1;
    repeat (width) @(negedge clk);
    event_pin = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    int v;
    chk("R1 run_o", int'(run_o), 0);
    chk("R1 irq_o", int'(irq_o), 0);
    rd(0, v); chk("R1 reload", v, 0);
    rd(1, v); chk("R1 count", v, 0);
    rd(2, v); chk("R1 mode", v, 0);
    rd(3, v); chk("R1 status", v, 0);
  endtask

  task automatic t_start;
    int v;
    wr(0, 3);
    wr(3, 1);
    chk("R2 run_o", int'(run_o), 1);
    rd(1, v); chk("R2 count loaded", v, 3);
    rd(3, v); chk("R2 status run, triggers 0", v, 4);
  endtask

  task automatic t_count;
    int v;
    int base;
    base = irq_cnt;
    for (int i = 0; i < 3; i++) pulse(2);
    rd(1, v); chk("R3 count after 3 edges", v, 0);
    chk("R4 no irq before zero edge", irq_cnt - base, 0);
    pulse(2);
    rd(1, v); chk("R4 reload at zero", v, 3);
    chk("R4 one irq", irq_cnt - base, 1);
    chk("R4 irq one clock wide", irq_max, 1);
  endtask

  task automatic t_reload_change;
    int v;
    wr(0, 1);
    rd(1, v); chk("R6 count not disturbed", v, 3);
    pulse(2);
    rd(1, v); chk("R7 live count readback", v, 2);
    pulse(2); pulse(2); pulse(2);
    rd(1, v); chk("R6 new reload used", v, 1);
  endtask

  task automatic t_mode_lock;
    int v;
    wr(2, 1);
    rd(2, v); chk("R8 mode write ignored while running", v, 0);
  endtask

  task automatic t_stop;
    int v;
    int base;
    wr(3, 2);
    chk("R5 run cleared", int'(run_o), 0);
    base = irq_cnt;
    pulse(2); pulse(2);
    rd(1, v); chk("R5 count held", v, 1);
    chk("R5 no irq while stopped", irq_cnt - base, 0);
    wr(3, 3);
    chk("R5 stop wins over start", int'(run_o), 0);
    wr(2, 1);
    rd(2, v); chk("R8 mode write taken while stopped", v, 1);
  endtask

  task automatic t_edges;
    int v;
    wr(0, 10);
    wr(3, 1);
    pin_to(1'b1);
    rd(1, v); chk("R9 rising counts on rise", v, 9);
    pin_to(1'b0);
    rd(1, v); chk("R9 rising ignores fall", v, 9);
    wr(3, 2); wr(2, 2); wr(3, 1);
    pulse(3);
    rd(1, v); chk("R9 both edges", v, 8);
    wr(3, 2); wr(2, 3); wr(3, 1);
    pin_to(1'b1);
    rd(1, v); chk("R9 reserved ignores rise", v, 10);
    pin_to(1'b0);
    rd(1, v); chk("R9 reserved counts fall", v, 9);
  endtask

  task automatic t_filter;
    int v;
    wr(3, 2); wr(2, 4); wr(3, 1);
    pulse(1);
    rd(1, v); chk("R10 filter rejects 1-clock pulse", v, 10);
    pulse(3);
    rd(1, v); chk("R10 filter passes 3-clock pulse", v, 9);
    wr(3, 2); wr(2, 0); wr(3, 1);
    pulse(1);
    rd(1, v); chk("R10 no filter passes 1-clock pulse", v, 9);
  endtask

  task automatic t_latency(input logic filt);
    string tag;
    tag = filt ? "R11 filtered" : "R11 unfiltered";
    wr(3, 2); wr(0, 0); wr(2, filt ? 4 : 0); wr(3, 1);
    pin_to(1'b1);
    @(negedge clk);
    event_pin = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); chk({tag, " early"}, int'(irq_o), 0);
    if (filt) begin
      @(negedge clk); chk({tag, " early+1"}, int'(irq_o), 0);
    end
    @(negedge clk); chk({tag, " irq due"}, int'(irq_o), 1);
    @(negedge clk); chk({tag, " irq dropped"}, int'(irq_o), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_start;
    t_count;
    t_reload_change;
    t_mode_lock;
    t_stop;
    t_edges;
    t_filter;
    t_latency(1'b0);
    t_latency(1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule